// File: doc/BRIEF.md
# PPS-Synchronised Timekeeper

This block keeps a free-running 64-bit time value made of a seconds half and a ticks half. The ticks half counts up by one on every clock and rolls over into the seconds half at a rate set by software. This lets the same counter hold wall-clock time at any sample clock frequency.

Software sets the time through a simple settings port, where each write carries an address and a 32-bit data word. It first writes a pending seconds value and then a pending ticks value. The ticks write arms a load. The armed pair is copied into the live counter either on the next clock or on the next pulse-per-second edge. For the PPS case, a flags word selects which of two PPS inputs is used and whether its rising or falling edge counts. Both PPS inputs are asynchronous and are synchronised inside the block before any edge is detected.

Top module: `pps_timekeeper`

## Requirements
- R1: Reset clears the live time and both pending values to zero. It sets the rollover value to all ones, both flags to 0 and the immediate control to 0, and leaves no load armed.
- R2: When no load applies and ticks is below the rollover value minus one, ticks increases by one on every clock and seconds holds.
- R3: When no load applies and ticks equals the rollover value minus one (rollover value at least 1), the next clock sets ticks to 0 and increases seconds by one.
- R4: A write to settings address 28 stores the pending seconds. A write to address 29 stores the pending ticks and arms a load. A write to address 28 alone never changes the live time.
- R5: When address 31 bit 0 holds 1, an armed load is applied on the clock edge that follows the ticks write. After that edge, time_now shows the pending pair: seconds in bits 63:32 and ticks in bits 31:0.
- R6: When address 31 bit 0 holds 0, an armed load is applied only on a detected edge of the selected PPS input. Until then, counting continues unchanged.
- R7: Bit 0 of the flags word at address 30 selects the PPS edge: 0 means falling, 1 means rising. An edge of the other polarity does not load.
- R8: Bit 1 of the flags word at address 30 selects the PPS input: 0 means pps_a, 1 means pps_b. Edges on the other input do not load.
- R9: A level change on a PPS input that is first sampled at clock edge e+1 loads the time at edge e+3, after two synchroniser stages and one edge-history stage. The live time is not yet loaded at edges e+1 and e+2.
- R10: A load disarms once it has been applied, so later PPS edges do not reload the time until address 29 is written again.
- R11: A write to settings address 32 sets the rollover value used by R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | AW (8) | Settings register address |
| set_data | input | W (32) | Settings write data |
| pps_a | input | 1 | First PPS input, asynchronous |
| pps_b | input | 1 | Second PPS input, asynchronous |
| time_now | output | 2*W (64) | Live time, seconds in the upper half and ticks in the lower half |

## Verification
The assertions assume two things about the inputs. First, software writes the rollover value before any load that depends on it. Second, the live ticks never sit above the rollover value minus one, so the count and wrap properties cover every cycle without a load. The stimulus keeps to this in two ways. It only changes the rollover value before an immediate load that rebases the ticks below it. It also holds each PPS level for many clocks, so that every change passes the synchroniser as a clean single edge.

// File: rtl/pps_timekeeper.sv
module pps_timekeeper #(
  parameter int AW = 8,
  parameter int W = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SECS_REG = 28,
  parameter int TICKS_REG = 29,
  parameter int FLAGS_REG = 30,
  parameter int IMM_REG = 31,
  parameter int RATE_REG = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_stb,
  input  logic [AW-1:0]  set_addr,
  input  logic [W-1:0]   set_data,
  input  logic           pps_a,
  input  logic           pps_b,
  output logic [2*W-1:0] time_now
);

  localparam int HS = SYNC_STAGES;

  logic [W-1:0] secs, ticks, pend_secs, pend_ticks, rate;
  logic rise_sel, src_b, imm, armed;
  logic [HS:0] hist_a, hist_b;

  wire wr_secs  = set_stb && set_addr == AW'(SECS_REG);
  wire wr_ticks = set_stb && set_addr == AW'(TICKS_REG);
  wire wr_flags = set_stb && set_addr == AW'(FLAGS_REG);
  wire wr_imm   = set_stb && set_addr == AW'(IMM_REG);
  wire wr_rate  = set_stb && set_addr == AW'(RATE_REG);

  wire cur = src_b ? hist_b[HS-1] : hist_a[HS-1];
  wire prv = src_b ? hist_b[HS]   : hist_a[HS];
  wire pps_edge = rise_sel ? (cur & ~prv) : (~cur & prv);
  wire do_load = armed && (imm || pps_edge);
  wire at_wrap = ticks >= rate - W'(1);

  assign time_now = {secs, ticks};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_a <= '0;
      hist_b <= '0;
    end else begin
      hist_a <= {hist_a[HS-1:0], pps_a};
      hist_b <= {hist_b[HS-1:0], pps_b};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_secs  <= '0;
      pend_ticks <= '0;
      rate       <= '1;
      rise_sel   <= 1'b0;
      src_b      <= 1'b0;
      imm        <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (wr_secs)  pend_secs <= set_data;
      if (wr_ticks) pend_ticks <= set_data;
      if (wr_flags) {src_b, rise_sel} <= set_data[1:0];
      if (wr_imm)   imm <= set_data[0];
      if (wr_rate)  rate <= set_data;
      if (wr_ticks)     armed <= 1'b1;
      else if (do_load) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      secs  <= '0;
      ticks <= '0;
    end else if (do_load) begin
      secs  <= pend_secs;
      ticks <= pend_ticks;
    end else if (at_wrap) begin
      secs  <= secs + W'(1);
      ticks <= '0;
    end else begin
      ticks <= ticks + W'(1);
    end
  end

  assert_count_R2: assert property (@(posedge clk) disable iff (rst)
    (!do_load && ticks < rate - W'(1)) |=> (ticks == $past(ticks) + W'(1) && $stable(secs)));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!do_load && rate != '0 && ticks == rate - W'(1)) |=> (ticks == '0 && secs == $past(secs) + W'(1)));

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (time_now == {$past(pend_secs), $past(pend_ticks)}));

  assert_disarm_R10: assert property (@(posedge clk) disable iff (rst)
    (do_load && !wr_ticks) |=> !armed);

  assert_noload_R6: assert property (@(posedge clk) disable iff (rst)
    (!armed && !wr_ticks) |=> !armed);

endmodule

// File: tb/pps_timekeeper_test.sv
module pps_timekeeper_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, set_stb = 1'b0, pps_a = 1'b0, pps_b = 1'b0;
  logic [7:0] set_addr = '0;
  logic [31:0] set_data = '0;
  logic [63:0] time_now;

  pps_timekeeper uut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
    .set_data(set_data), .pps_a(pps_a), .pps_b(pps_b), .time_now(time_now)
  );

  typedef struct {
    int at;
    logic [63:0] val;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int errs = 0;
  int checks = 0;
  longint unsigned bs = 0, bt = 0, rate = 64'h1_0000_0000;
  int bc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] model(int c);
    longint unsigned t;
    t = bt + longint'(c - bc);
    return {32'(bs + t / rate), 32'(t % rate)};
  endfunction

  task automatic push(int from, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.at = from + i;
      it.val = model(from + i);
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    while (q.size() > 0 && q[0].at <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.at != cyc || time_now !== it.val) begin
        errs++;
        $display("FAIL %s: actual=%h expected=%h at cycle %0d", it.tag, time_now, it.val, cyc);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int k);
    @(negedge clk);
    set_stb = 1'b1; set_addr = a; set_data = d;
    k = cyc + 1;
    @(negedge clk);
    set_stb = 1'b0;
  endtask

  task automatic set_pps(input bit on_b, input logic v, output int c);
    @(negedge clk);
    if (on_b) pps_b = v; else pps_a = v;
    c = cyc;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int k, c;
    repeat (3) @(negedge clk);
    checks++;
    if (time_now !== 64'd0) begin
      errs++;
      $display("FAIL R1 reset time: actual=%h expected=%h", time_now, 64'd0);
    end
    @(negedge clk);
    rst = 1'b0;
    k = cyc + 1;
    bs = 0; bt = 1; bc = k;
    push(k + 1, 6, "R1/R2 count from reset with maximal rollover");
    drain();

    wr(8'd32, 32'd10, k);   // R11 rollover at 10
    wr(8'd31, 32'd1, k);
    wr(8'd28, 32'd5, k);
    wr(8'd29, 32'd7, k);
    rate = 10; bs = 5; bt = 7; bc = k + 1;
    push(k + 1, 3, "R5 immediate load");
    push(k + 4, 12, "R3 R11 rollover at programmed rate");
    drain();

    wr(8'd31, 32'd0, k);
    wr(8'd28, 32'd100, k);
    push(k + 1, 3, "R4 seconds write alone leaves time");
    drain();
    wr(8'd29, 32'd3, k);
    push(k + 1, 8, "R6 pending pair held until PPS");
    drain();

    set_pps(1'b0, 1'b1, c);
    push(c + 1, 10, "R7 rising edge ignored while falling selected");
    drain();
    set_pps(1'b0, 1'b0, c);
    push(c + 1, 2, "R9 no load before synchroniser delay");
    bs = 100; bt = 3; bc = c + 3;
    push(c + 3, 6, "R6 R9 load on falling edge of first input");
    drain();

    set_pps(1'b0, 1'b1, c);
    repeat (6) @(negedge clk);
    set_pps(1'b0, 1'b0, c);
    push(c + 1, 10, "R10 no reload after disarm");
    drain();

    wr(8'd30, 32'd3, k);
    wr(8'd28, 32'd200, k);
    wr(8'd29, 32'd9, k);
    set_pps(1'b0, 1'b1, c);
    push(c + 1, 10, "R8 unselected first input ignored");
    drain();

    set_pps(1'b1, 1'b1, c);
    push(c + 1, 2, "R9 second input not loaded early");
    bs = 200; bt = 9; bc = c + 3;
    push(c + 3, 6, "R7 R8 rising edge of second input loads");
    drain();

    summary();
    $finish;
  end
endmodule